// File: doc/BRIEF.md
# Four-Stage Shift Register with J-K Serial Head

This block is a small register of WIDTH stages (four by default), numbered from stage 0, the head, to stage WIDTH-1, the tail. One control input picks between two synchronous modes on each rising clock edge. In LOAD mode every stage takes its own bit from a parallel data word. In SHIFT mode the contents move one place toward the tail. The head stage then takes a new value set by a serial pair made of a J input and an inverted K input. That pair can force the head to 0 or 1, keep it, or flip it.

An active-low clear input drives every stage to zero at once, with no clock needed, and overrides every other input. Besides the stage values, the block drives the inverse of the tail stage. A typical use takes bits in serially through the J-K pair, or in parallel through a load, and reads them out in parallel or from the tail.

The mode is a two-value enumeration. MODE_LOAD is selected when `shift_load` is 0 and MODE_SHIFT when it is 1. The block has no sequencing state, so either mode can follow the other on any edge. In MODE_SHIFT the head action is decoded from `{j, k_n}` into one of four named actions: HEAD_CLR (00), HEAD_HOLD (01), HEAD_TOG (10) and HEAD_SET (11).

Top module: `jkshift_reg`

## Requirements
- R1: While `clear_n` is 0, `q` is all zeros. It goes to zero as soon as `clear_n` falls, without waiting for a clock edge, and stays zero across rising edges for as long as `clear_n` stays low.
- R2: With `clear_n` at 1 and `shift_load` at 0, a rising edge copies `par_in` into `q` bit for bit. `par_in[i]` goes to `q[i]`, and `q[0]` is the head.
- R3: In MODE_LOAD, the values on `j` and `k_n` have no effect on the result of the edge.
- R4: With `clear_n` at 1 and `shift_load` at 1, a rising edge moves `q[i-1]` into `q[i]` for every i from 1 to WIDTH-1.
- R5: In MODE_SHIFT, the next head bit `q[0]` depends on `{j, k_n}`. The value 00 gives 0, 11 gives 1, 10 gives the inverse of the old `q[0]`, and 01 keeps the old `q[0]`.
- R6: Between rising edges, with `clear_n` high, `q` keeps its value whatever the other inputs do.
- R7: `q_last_n` is always the inverse of `q[WIDTH-1]`.
- R8: After WIDTH shift edges, the bit that entered the head on the first of those edges is found in `q[WIDTH-1]`.
- R9: Raising `clear_n` changes nothing by itself. The first rising edge after the release performs the selected mode normally, starting from all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low asynchronous clear of all stages |
| shift_load | input | 1 | Mode select: 0 = parallel load, 1 = shift |
| j | input | 1 | Serial J input for the head stage |
| k_n | input | 1 | Serial inverted-K input for the head stage |
| par_in | input | WIDTH | Parallel data; bit 0 goes to the head |
| q | output | WIDTH | Stage values; bit 0 is the head, bit WIDTH-1 the tail |
| q_last_n | output | 1 | Inverse of the tail stage |

## Verification
The clocked assertions compare each stage with its value at the previous edge. They therefore assume that any low pulse on `clear_n` still covers a rising edge, because a pulse that starts and ends between two edges would break that comparison. The bench follows this rule. Every clear it applies, directed or random, goes low at a falling edge and stays low through at least one rising edge. The mid-cycle clear test checks that the outputs drop before the next edge and keeps the clear held until after that edge. All other inputs change only at falling edges, which gives them half a period to settle before each rising edge.

// File: rtl/jkshift_pkg.sv
package jkshift_pkg;

    // Operating mode chosen by the shift_load pin
    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } mode_e;

    // Head-stage action, encoded as {j, k_n}
    typedef enum logic [1:0] {
        HEAD_CLR  = 2'b00,
        HEAD_HOLD = 2'b01,
        HEAD_TOG  = 2'b10,
        HEAD_SET  = 2'b11
    } head_act_e;

endpackage

// File: rtl/jkshift_head.sv
module jkshift_head
    import jkshift_pkg::*;
(
    input  logic j,
    input  logic k_n,
    input  logic cur_bit,
    output logic nxt_bit
);

    head_act_e act;

    always_comb begin
        act = head_act_e'({j, k_n});
    end

    always_comb begin
        unique case (act)
            HEAD_CLR:  nxt_bit = 1'b0;
            HEAD_HOLD: nxt_bit = cur_bit;
            HEAD_TOG:  nxt_bit = ~cur_bit;
            HEAD_SET:  nxt_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/jkshift_next.sv
module jkshift_next
    import jkshift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mode_e             mode,
    input  logic [WIDTH-1:0]  par_in,
    input  logic [WIDTH-1:0]  cur_q,
    input  logic              head_nxt,
    output logic [WIDTH-1:0]  nxt_q
);

    // Head stage: parallel bit or J-K result
    always_comb begin
        unique case (mode)
            MODE_LOAD:  nxt_q[0] = par_in[0];
            MODE_SHIFT: nxt_q[0] = head_nxt;
        endcase
    end

    // Remaining stages: parallel bit or the neighbour nearer the head
    for (genvar gi = 1; gi < WIDTH; gi++) begin : g_stage
        always_comb begin
            unique case (mode)
                MODE_LOAD:  nxt_q[gi] = par_in[gi];
                MODE_SHIFT: nxt_q[gi] = cur_q[gi-1];
            endcase
        end
    end

endmodule

// File: rtl/jkshift_regs.sv
module jkshift_regs #(
    parameter int WIDTH = 4
) (
    input  logic              clk,
    input  logic              clear_n,
    input  logic [WIDTH-1:0]  d,
    output logic [WIDTH-1:0]  q
);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_ff
        always_ff @(posedge clk or negedge clear_n) begin
            if (!clear_n) begin
                q[gi] <= 1'b0;
            end else begin
                q[gi] <= d[gi];
            end
        end
    end

endmodule

// File: rtl/jkshift_reg.sv
module jkshift_reg
    import jkshift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic              clk,
    input  logic              clear_n,
    input  logic              shift_load,
    input  logic              j,
    input  logic              k_n,
    input  logic [WIDTH-1:0]  par_in,
    output logic [WIDTH-1:0]  q,
    output logic              q_last_n
);

    localparam int LAST = WIDTH - 1;

    mode_e             mode;
    logic              head_nxt;
    logic [WIDTH-1:0]  nxt_q;

    always_comb begin
        mode = shift_load ? MODE_SHIFT : MODE_LOAD;
    end

    jkshift_head u_head (
        .j       (j),
        .k_n     (k_n),
        .cur_bit (q[0]),
        .nxt_bit (head_nxt)
    );

    jkshift_next #(.WIDTH(WIDTH)) u_next (
        .mode     (mode),
        .par_in   (par_in),
        .cur_q    (q),
        .head_nxt (head_nxt),
        .nxt_q    (nxt_q)
    );

    jkshift_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .clear_n (clear_n),
        .d       (nxt_q),
        .q       (q)
    );

    always_comb begin
        q_last_n = ~q[LAST];
    end

    // R1: clear held low keeps all stages at zero across edges
    a_r1_clear_zero: assert property (@(posedge clk)
        !clear_n |-> (q == '0));

    // R2 / R3: load copies the parallel word, whatever j and k_n are
    a_r2_load_copy: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && !$past(shift_load)) |-> (q == $past(par_in)));

    // R4: shift moves every stage one place toward the tail
    a_r4_shift_move: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && $past(shift_load)) |-> (q[LAST:1] == $past(q[LAST-1:0])));

    // R5: head stage follows the J-K action table
    a_r5_head_clr: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && $past(shift_load) && !$past(j) && !$past(k_n)) |-> (q[0] == 1'b0));

    a_r5_head_set: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && $past(shift_load) && $past(j) && $past(k_n)) |-> (q[0] == 1'b1));

    a_r5_head_tog: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && $past(shift_load) && $past(j) && !$past(k_n)) |-> (q[0] != $past(q[0])));

    a_r5_head_hold: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && $past(shift_load) && !$past(j) && $past(k_n)) |-> $stable(q[0]));

endmodule

// File: tb/jkshift_reg_tb.sv
module jkshift_reg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          clear_n;
    logic          shift_load;
    logic          j;
    logic          k_n;
    logic [W-1:0]  par_in;
    logic [W-1:0]  q;
    logic          q_last_n;

    logic [W-1:0]  m_q;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            finished = 0;

    jkshift_reg #(.WIDTH(W)) dut_i (
        .clk        (clk),
        .clear_n    (clear_n),
        .shift_load (shift_load),
        .j          (j),
        .k_n        (k_n),
        .par_in     (par_in),
        .q          (q),
        .q_last_n   (q_last_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] ref_next(logic [W-1:0] cur, logic sl,
                                              logic jj, logic kk, logic [W-1:0] par);
        logic [W-1:0] r;
        logic h;
        if (!sl) return par;
        r = cur << 1;
        case ({jj, kk})
            2'b00:   h = 1'b0;
            2'b01:   h = cur[0];
            2'b10:   h = ~cur[0];
            default: h = 1'b1;
        endcase
        r[0] = h;
        return r;
    endfunction

    task automatic check_vec(string rid, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", rid, act, exp, $time);
        end
    endtask

    task automatic check_bit(string rid, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", rid, act, exp, $time);
        end
    endtask

    // Called at a falling edge: drive, take one rising edge, compare at next falling edge
    task automatic step(logic sl, logic jj, logic kk, logic [W-1:0] par, string rid);
        shift_load = sl; j = jj; k_n = kk; par_in = par;
        @(posedge clk);
        m_q = ref_next(m_q, sl, jj, kk, par);
        @(negedge clk);
        check_vec(rid, q, m_q);
        check_bit("R7", q_last_n, ~m_q[W-1]);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [W-1:0] held;
        logic         first_in;
        void'($urandom(32'h0000_5eed));
        clear_n = 1'b0; shift_load = 1'b0; j = 1'b0; k_n = 1'b0; par_in = '1;
        m_q = '0;
        repeat (2) @(negedge clk);
        check_vec("R1", q, '0);
        check_bit("R7", q_last_n, 1'b1);

        // R9: release at a falling edge; the first rising edge loads normally
        clear_n = 1'b1;
        #1 check_vec("R9", q, '0);
        @(negedge clk);
        step(1'b0, 1'b0, 1'b0, 4'b1011, "R9");
        step(1'b0, 1'b1, 1'b0, 4'b0101, "R3");
        step(1'b0, 1'b1, 1'b1, 4'b1110, "R3");
        step(1'b0, 1'b0, 1'b1, 4'b0001, "R2");

        // R6: inputs move between edges, outputs stay
        held = q;
        shift_load = 1'b1; j = 1'b1; k_n = 1'b0; par_in = 4'b1010;
        #2 par_in = 4'b0110; j = 1'b0;
        #1 check_vec("R6", q, held);
        @(negedge clk);
        m_q = ref_next(m_q, 1'b1, 1'b0, 1'b0, 4'b0110);
        check_vec("R4", q, m_q);

        // R8: serial bits walk to the tail
        step(1'b0, 1'b0, 1'b0, 4'b0000, "R2");
        first_in = 1'b1;
        step(1'b1, 1'b1, 1'b1, 4'b1111, "R4");
        step(1'b1, 1'b0, 1'b0, 4'b1111, "R4");
        step(1'b1, 1'b0, 1'b0, 4'b0000, "R4");
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R4");
        check_bit("R8", q[W-1], first_in);
        check_bit("R7", q_last_n, ~first_in);

        // R5: every head action
        step(1'b0, 1'b0, 1'b0, 4'b0000, "R2");
        step(1'b1, 1'b1, 1'b0, 4'b0000, "R5");
        step(1'b1, 1'b1, 1'b0, 4'b0000, "R5");
        step(1'b1, 1'b1, 1'b0, 4'b0000, "R5");
        step(1'b1, 1'b0, 1'b1, 4'b0000, "R5");
        step(1'b1, 1'b0, 1'b1, 4'b0000, "R5");
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R5");
        step(1'b1, 1'b0, 1'b0, 4'b1111, "R5");

        // R1: clear mid-cycle acts at once and outlasts a rising edge
        step(1'b0, 1'b0, 1'b0, 4'b1111, "R2");
        clear_n = 1'b0;
        #1 check_vec("R1", q, '0);
        shift_load = 1'b0; par_in = 4'b1001;
        @(negedge clk);
        check_vec("R1", q, '0);
        m_q = '0;
        clear_n = 1'b1;
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R9");

        // Random mix of loads, shifts and edge-spanning clears
        for (int it = 0; it < 300; it++) begin
            if (($urandom % 16) == 0) begin
                clear_n = 1'b0;
                shift_load = $urandom; j = $urandom; k_n = $urandom; par_in = $urandom;
                @(negedge clk);
                m_q = '0;
                check_vec("R1", q, '0);
                clear_n = 1'b1;
            end else begin
                logic sl;
                sl = $urandom;
                step(sl, 1'($urandom), 1'($urandom), W'($urandom), sl ? "R4" : "R2");
            end
        end

        report();
    end

endmodule